// File: doc/BRIEF.md
# Serial Bus Peripheral Mode Controller

This block selects the operating mode of a byte-level vehicle serial bus decoder peripheral. The selection comes from two control bits, enable and disable, which a CPU register write loads. From the current pair of bits the block does four things:

- It decides whether the line decoder keeps running.
- It decides whether the rest of the peripheral runs and may transmit or receive.
- It produces the clear strobes that hold the status, error, sleep, interrupt-mask and end-of-byte flag registers at their reset values.
- It tracks whether the decoder is synchronized to bus traffic.

There are three legal modes. In Enabled, everything runs. In Suspended, only the decoder runs, so it stays synchronized for an immediate restart. In Disabled, everything stops and synchronization is lost until a new bus idle is seen. A write may not set enable together with disable, and may not set enable in the same write that clears disable. Such a write leaves enable at 0 and raises a one-cycle illegal-write pulse. The mask and end-of-byte clears take effect only after disable has been held for a minimum number of cycles.

Top module: `serial_mode_ctrl`

## Requirements
- R1: After reset, en_bit=0, dis_bit=0, mode=2'b00 (Suspended), synced=0 and illegal_wr=0.
- R2: A write (ctl_we=1) is visible on en_bit/dis_bit from the next cycle. dis_bit takes the written disable value. mode reads 2'b10 when dis_bit=1, 2'b01 when en_bit=1, and 2'b00 otherwise. en_bit and dis_bit are never both 1.
- R3: In Enabled mode, dec_run=1, core_run=1, txrx_ok=1, clr_ses=0 and clr_mask_eob=0.
- R4: In Suspended mode, dec_run=1, core_run=0, txrx_ok=0, clr_ses=1 and clr_mask_eob=0.
- R5: In Disabled mode, dec_run=0, core_run=0, txrx_ok=0 and clr_ses=1.
- R6: clr_mask_eob is 1 only in the cycles in which dis_bit has read 1 for more than HOLD_CYCLES (default 6) consecutive cycles, counting the current cycle. It therefore first rises in the seventh such cycle, and it falls in the first cycle in which dis_bit reads 0.
- R7: A write with enable=1 that also writes disable=1, or that occurs while dis_bit=1, leaves en_bit at 0. illegal_wr is 1 in exactly the cycle after such a write, and 0 otherwise.
- R8: synced becomes 1 in the cycle after a cycle with bus_idle=1 and dis_bit=0. It becomes 0 in the cycle after any cycle with dis_bit=1. A bus_idle seen while dis_bit=1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_en_wr | input | 1 | Enable value carried by the write |
| ctl_dis_wr | input | 1 | Disable value carried by the write |
| bus_idle | input | 1 | Bus idle indication from the line monitor |
| en_bit | output | 1 | Current enable bit |
| dis_bit | output | 1 | Current disable bit |
| mode | output | 2 | 00 Suspended, 01 Enabled, 10 Disabled |
| dec_run | output | 1 | Line decoder run enable |
| core_run | output | 1 | Run enable for the remaining logic |
| txrx_ok | output | 1 | Transmit/receive permitted |
| clr_ses | output | 1 | Hold status, error and sleep flag at reset |
| clr_mask_eob | output | 1 | Hold interrupt mask and end-of-byte flags at reset |
| synced | output | 1 | Decoder synchronized to the bus |
| illegal_wr | output | 1 | One-cycle pulse after a rejected enable write |

## Verification
Two events can fall in the same cycle: a write that clears disable, and a bus idle pulse. The idle arrives while disable still reads 1, so it must not set synced; only a later idle may. The enable-rejection rule and the disable hold counter also meet when a write sets enable and clears disable at once, for example after a disable held for only a few cycles. Directed steps force both collisions. Random sequences with dense writes and idles then repeat them against a cycle model in the bench.

// File: rtl/serial_mode_ctrl.sv
`timescale 1ns/1ps
module serial_mode_ctrl #(
  parameter int HOLD_CYCLES = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic       ctl_en_wr,
  input  logic       ctl_dis_wr,
  input  logic       bus_idle,
  output logic       en_bit,
  output logic       dis_bit,
  output logic [1:0] mode,
  output logic       dec_run,
  output logic       core_run,
  output logic       txrx_ok,
  output logic       clr_ses,
  output logic       clr_mask_eob,
  output logic       synced,
  output logic       illegal_wr
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_CYCLES);

  logic en_q, dis_q, sync_q, ill_q;
  logic [CNT_W-1:0] hold_cnt;
  logic en_reject;

  assign en_reject = ctl_we & ctl_en_wr & (ctl_dis_wr | dis_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      dis_q <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      ill_q <= en_reject;
      if (ctl_we) begin
        dis_q <= ctl_dis_wr;
        en_q  <= ctl_en_wr & ~ctl_dis_wr & ~dis_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            hold_cnt <= '0;
    else if (!dis_q)       hold_cnt <= '0;
    else if (hold_cnt != HOLD_V) hold_cnt <= hold_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sync_q <= 1'b0;
    else if (dis_q) sync_q <= 1'b0;
    else if (bus_idle) sync_q <= 1'b1;
  end

  assign en_bit       = en_q;
  assign dis_bit      = dis_q;
  assign mode         = dis_q ? 2'b10 : (en_q ? 2'b01 : 2'b00);
  assign dec_run      = ~dis_q;
  assign core_run     = en_q;
  assign txrx_ok      = en_q & ~dis_q;
  assign clr_ses      = ~en_q;
  assign clr_mask_eob = dis_q & (hold_cnt == HOLD_V);
  assign synced       = sync_q;
  assign illegal_wr   = ill_q;

  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_bit && dis_bit)); // R2
  AST_EN_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_bit) |-> $past(!dis_bit)); // R7
  AST_TXRX_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    txrx_ok |-> (core_run && dec_run)); // R3
  AST_DIS_STOPS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    dis_bit |-> (!dec_run && !core_run && clr_ses)); // R5
  AST_NO_EARLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dis_bit) |-> !clr_mask_eob); // R6
  AST_CLEAR_NEEDS_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_mask_eob |-> (dis_bit && $past(dis_bit))); // R6
  AST_SYNC_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    dis_bit |=> !synced); // R8
  AST_ILLEGAL_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_wr |-> $past(ctl_we && ctl_en_wr)); // R7
endmodule

// File: tb/tb_serial_mode_ctrl.sv
`timescale 1ns/1ps
module tb_serial_mode_ctrl;
  localparam int HOLD = 6;
  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, ctl_en_wr = 0, ctl_dis_wr = 0, bus_idle = 0;
  logic en_bit, dis_bit, dec_run, core_run, txrx_ok, clr_ses, clr_mask_eob, synced, illegal_wr;
  logic [1:0] mode;
  int tests = 0, fails = 0;
  bit m_en, m_dis, m_sync, m_ill;
  int m_run;

  always #2 clk = ~clk;

  serial_mode_ctrl #(.HOLD_CYCLES(HOLD)) dut (.*);

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_mode();
    return m_dis ? 2 : (m_en ? 1 : 0);
  endfunction

  task automatic check_all();
    chk("R2 en_bit", en_bit, m_en);
    chk("R2 dis_bit", dis_bit, m_dis);
    chk("R2 mode", mode, exp_mode());
    chk("R3/R4/R5 dec_run", dec_run, !m_dis);
    chk("R3/R4/R5 core_run", core_run, m_en);
    chk("R3/R4/R5 txrx_ok", txrx_ok, m_en);
    chk("R3/R4/R5 clr_ses", clr_ses, !m_en);
    chk("R6 clr_mask_eob", clr_mask_eob, (m_dis && m_run > HOLD) ? 1 : 0);
    chk("R8 synced", synced, m_sync);
    chk("R7 illegal_wr", illegal_wr, m_ill);
  endtask

  task automatic step(bit we, bit en, bit dis, bit idle);
    bit ill_n, en_n, dis_n, sync_n;
    ctl_we = we; ctl_en_wr = en; ctl_dis_wr = dis; bus_idle = idle;
    @(posedge clk);
    ill_n  = we && en && (dis || m_dis);
    en_n   = we ? (en && !dis && !m_dis) : m_en;
    dis_n  = we ? dis : m_dis;
    sync_n = m_dis ? 0 : (m_sync || idle);
    m_en = en_n; m_dis = dis_n; m_sync = sync_n; m_ill = ill_n;
    m_run = m_dis ? m_run + 1 : 0;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_en = 0; m_dis = 0; m_sync = 0; m_ill = 0; m_run = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 en_bit", en_bit, 0);
    chk("R1 dis_bit", dis_bit, 0);
    chk("R1 mode", mode, 0);
    chk("R1 synced", synced, 0);
    chk("R1 illegal_wr", illegal_wr, 0);
    rst_n = 1;
    @(negedge clk);
    check_all();
    // R8 idle in suspended mode synchronizes
    step(0, 0, 0, 1);
    chk("R8 synced after idle", synced, 1);
    // R3 enable from suspended
    step(1, 1, 0, 0);
    chk("R3 txrx_ok", txrx_ok, 1);
    // R7 both set is rejected for enable
    step(1, 1, 1, 0);
    chk("R7 illegal both", illegal_wr, 1);
    chk("R7 en rejected", en_bit, 0);
    // R6 short hold: 5 cycles then clear, no strobe
    repeat (4) step(0, 0, 0, 0);
    chk("R6 no early clear", clr_mask_eob, 0);
    // R7 clear disable with enable in same write; R8 idle same cycle ignored
    step(1, 1, 0, 1);
    chk("R7 clear+enable rejected", en_bit, 0);
    chk("R7 pulse", illegal_wr, 1);
    chk("R8 idle during disable ignored", synced, 0);
    step(0, 0, 0, 1);
    chk("R8 resync", synced, 1);
    // R6 long hold
    step(1, 0, 1, 0);
    repeat (HOLD - 1) step(0, 0, 0, 1);
    chk("R6 not yet", clr_mask_eob, 0);
    step(0, 0, 0, 0);
    chk("R6 clear on seventh", clr_mask_eob, 1);
    repeat (3) step(0, 0, 0, 0);
    step(1, 0, 0, 0);
    chk("R6 drops with disable", clr_mask_eob, 0);
    step(1, 1, 0, 0);
    chk("R3 enabled after later write", en_bit, 1);
    // random
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      bit we = ($urandom % 4) == 0;
      bit dis = ($urandom % 3) == 0;
      step(we, $urandom % 2, dis, ($urandom % 5) == 0);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule